// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Lockable Lower Half

This block is the slave side of an I2C-compatible serial memory holding 256 bytes. Both bus lines are sampled in the system clock domain and pass through a synchronizer. The controller detects START and STOP conditions, decodes the device select byte, and serves four operations: byte write, sequential write, current-address read and random/sequential read. SDA is open-drain. The block never drives it high: it only asserts an output enable that pulls the line low.

Select bytes that carry the array type code reach the memory. Select bytes that carry the guard type code reach a small protection unit instead. For a guard access, the byte after the select is a command that can do three things: set a clearable lock on addresses 00h–7Fh, set a lock on that range that can never be cleared, or remove the clearable lock. A write-control input blocks writes to the whole array while it is high. A blocked data byte is not acknowledged, and memory keeps its old value. Writes complete at once, in the cycle the data byte ends.

The controller has the following states:
- ST_IDLE: the bus is free.
- ST_DEVSEL: shifting in the select byte.
- ST_DEV_ACK: acknowledge slot for the select byte.
- ST_WORD: shifting in the address or command byte.
- ST_WORD_ACK: acknowledge slot for that byte.
- ST_WDATA: shifting in a data byte.
- ST_WDATA_ACK: acknowledge slot for the data byte.
- ST_RDATA: shifting a data byte out.
- ST_RD_ACK: sampling the master's acknowledge.
- ST_IGNORE: waiting for the next START or STOP.

The transitions are as follows:
- START from any state leads to ST_DEVSEL.
- STOP from any state leads to ST_IDLE.
- Each byte state moves to its acknowledge state on the SCL fall that ends the 8th bit.
- ST_DEV_ACK moves to ST_RDATA (read), ST_WORD (write) or ST_IGNORE (no match).
- ST_WORD_ACK moves to ST_WDATA (array access) or ST_IGNORE (guard command done, or refused).
- ST_WDATA_ACK moves to ST_WDATA (acknowledged) or ST_IGNORE (refused).
- ST_RD_ACK moves to ST_RDATA (master acknowledge) or ST_IGNORE (master no-acknowledge).

Top module: `i2c_eep_slave`

## Requirements
- R1: A select byte is accepted only when bits 7:4 equal 1010b (array) or 0110b (guard) and bits 3:1 equal `chip_sel_i[2:1:0]` in that order. Bit 0 is the read (1) / write (0) flag. Any other select byte is not acknowledged, and the rest of the transfer has no effect on memory.
- R2: Byte write: after an acknowledged write select, the next byte sets the address pointer and is acknowledged. The following data byte is stored there and acknowledged. A random read sends a write select and an address, then a repeated START and a read select, and returns the stored byte.
- R3: The address pointer advances by one after every byte read or written. A read select with no address phase returns the byte at the current pointer.
- R4: Reads continue while the master acknowledges. The pointer wraps from FFh to 00h. A master no-acknowledge ends the read, and the slave releases SDA.
- R5: Consecutive data bytes in one write transfer go to consecutive addresses, and each is acknowledged. No page limit applies.
- R6: While `wr_ctrl_i` is 1, the select and address bytes of a write are still acknowledged. The data byte is not acknowledged, and memory is unchanged.
- R7: Guard command 00h (the byte after a guard write select) sets the clearable lock and is acknowledged. While any lock is set, data bytes to 00h–7Fh are not acknowledged and are not stored. Addresses 80h–FFh stay writable.
- R8: Guard command 02h removes the clearable lock and is acknowledged, provided the permanent lock is not set.
- R9: Guard command 01h sets the permanent lock and is acknowledged. From then on, command 02h is not acknowledged and the lower half stays protected until reset.
- R10: Guard command codes other than 00h, 01h and 02h are not acknowledged and change nothing. A guard select with the read flag set is not acknowledged.
- R11: A STOP ends any transfer and releases SDA. A new START always restarts select decoding, including a repeated START in the middle of a transfer.
- R12: After reset, SDA is released, the pointer is 00h, every byte reads 00h and no lock is set.
- R13: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bus lines are oversampled |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| chip_sel_i | input | 3 | Strap levels the select byte bits 3:1 must match |
| wr_ctrl_i | input | 1 | 1 blocks all array writes |

## Verification
Single-byte writes are read back through random reads, to confirm that the address byte really steers the pointer. Multi-byte writes and reads that cross FFh show whether the pointer increments and wraps. A read select with no address phase tells a pointer that was advanced correctly from one that was reset or left behind. Protected writes are tried on both halves under each lock mode and under the write-control pin. The acknowledge bit is read together with a later readback, so a design that refuses the byte but still stores it, or one that stores nothing but still acknowledges, both show up. Select bytes with a wrong type code or wrong strap bits, unknown commands, and an unlock after the permanent lock each check that refused traffic leaves the state untouched.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;

    localparam int BYTE_W   = 8;
    localparam int BITCNT_W = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_DEV_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_IGNORE
    } bus_state_e;

    localparam logic [3:0] TYPE_ARRAY = 4'b1010;
    localparam logic [3:0] TYPE_GUARD = 4'b0110;

    localparam logic [BYTE_W-1:0] CMD_LOCK_SOFT = 8'h00;
    localparam logic [BYTE_W-1:0] CMD_LOCK_HARD = 8'h01;
    localparam logic [BYTE_W-1:0] CMD_UNLOCK    = 8'h02;

endpackage

// File: rtl/i2c_eep_line_sync.sv
module i2c_eep_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_o      = scl_pipe[STAGES-1];
    assign sda_o      = sda_pipe[STAGES-1];
    assign scl_rise_o = scl_o & ~scl_d;
    assign scl_fall_o = ~scl_o & scl_d;
    assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
    assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;

endmodule

// File: rtl/i2c_eep_store.sv
module i2c_eep_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/i2c_eep_guard.sv
module i2c_eep_guard
    import i2c_eep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [BYTE_W-1:0] cmd_code_i,
    output logic              accept_o,
    output logic              locked_o
);

    logic soft_q;
    logic hard_q;

    always_comb begin
        case (cmd_code_i)
            CMD_LOCK_SOFT: accept_o = 1'b1;
            CMD_LOCK_HARD: accept_o = 1'b1;
            CMD_UNLOCK:    accept_o = ~hard_q;
            default:       accept_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_q <= 1'b0;
            hard_q <= 1'b0;
        end else if (cmd_valid_i && accept_o) begin
            case (cmd_code_i)
                CMD_LOCK_SOFT: soft_q <= 1'b1;
                CMD_LOCK_HARD: hard_q <= 1'b1;
                CMD_UNLOCK:    soft_q <= 1'b0;
                default:       soft_q <= soft_q;
            endcase
        end
    end

    assign locked_o = soft_q | hard_q;

    // R9
    hard_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hard_q) |-> hard_q);

    // R8
    soft_clear_only_unhard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_q) |-> !$past(hard_q));

endmodule

// File: rtl/i2c_eep_slave.sv
module i2c_eep_slave
    import i2c_eep_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] chip_sel_i,
    input  logic       wr_ctrl_i
);

    localparam int                TOP_BIT   = ADDR_W - 1;
    localparam logic [BITCNT_W-1:0] BITS_FULL = BITCNT_W'(BYTE_W);
    localparam logic [BITCNT_W-1:0] BITS_LAST = BITCNT_W'(BYTE_W - 1);

    bus_state_e          state_q, state_d;
    logic                scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [BITCNT_W-1:0] cnt_q;
    logic [BYTE_W-1:0]   sh_q, tx_q;
    logic [ADDR_W-1:0]   ptr_q;
    logic                ack_q, rw_q, guard_q, mack_q;
    logic                byte_done, sel_match, sel_array, sel_guard;
    logic                locked, cmd_accept, cmd_valid, write_ok, mem_we;
    logic [BYTE_W-1:0]   rd_data;

    i2c_eep_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    assign byte_done = scl_fall && (cnt_q == BITS_FULL);
    assign sel_match = (sh_q[3:1] == chip_sel_i);
    assign sel_array = sel_match && (sh_q[7:4] == TYPE_ARRAY);
    assign sel_guard = sel_match && (sh_q[7:4] == TYPE_GUARD) && !sh_q[0];
    assign write_ok  = !wr_ctrl_i && !(locked && !ptr_q[TOP_BIT]);
    assign mem_we    = (state_q == ST_WDATA) && byte_done && write_ok;
    assign cmd_valid = (state_q == ST_WORD) && byte_done && guard_q;

    i2c_eep_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .waddr_i (ptr_q),
        .wdata_i (sh_q),
        .raddr_i (ptr_q),
        .rdata_o (rd_data)
    );

    i2c_eep_guard guard_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid),
        .cmd_code_i  (sh_q),
        .accept_o    (cmd_accept),
        .locked_o    (locked)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (bus_stop) begin
            state_d = ST_IDLE;
        end else if (bus_start) begin
            state_d = ST_DEVSEL;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_DEVSEL:    if (byte_done) state_d = ST_DEV_ACK;
                ST_DEV_ACK:   if (scl_fall)  state_d = !ack_q ? ST_IGNORE :
                                                       (rw_q ? ST_RDATA : ST_WORD);
                ST_WORD:      if (byte_done) state_d = ST_WORD_ACK;
                ST_WORD_ACK:  if (scl_fall)  state_d = (ack_q && !guard_q) ? ST_WDATA : ST_IGNORE;
                ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  state_d = ack_q ? ST_WDATA : ST_IGNORE;
                ST_RDATA:     if (scl_fall && cnt_q == BITS_LAST) state_d = ST_RD_ACK;
                ST_RD_ACK:    if (scl_fall)  state_d = mack_q ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:    state_d = ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            sh_q    <= '0;
            tx_q    <= '0;
            ptr_q   <= '0;
            ack_q   <= 1'b0;
            rw_q    <= 1'b0;
            guard_q <= 1'b0;
            mack_q  <= 1'b0;
        end else if (bus_start || bus_stop) begin
            cnt_q <= '0;
            ack_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_DEVSEL, ST_WORD, ST_WDATA: begin
                    if (scl_rise) begin
                        sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
                        cnt_q <= cnt_q + 1'b1;
                    end else if (byte_done) begin
                        cnt_q <= '0;
                        if (state_q == ST_DEVSEL) begin
                            ack_q   <= sel_array || sel_guard;
                            guard_q <= sel_guard;
                            rw_q    <= sh_q[0];
                        end else if (state_q == ST_WORD) begin
                            if (guard_q) begin
                                ack_q <= cmd_accept;
                            end else begin
                                ack_q <= 1'b1;
                                ptr_q <= sh_q[ADDR_W-1:0];
                            end
                        end else begin
                            ack_q <= write_ok;
                            if (write_ok) ptr_q <= ptr_q + 1'b1;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall && ack_q && rw_q) begin
                        tx_q  <= rd_data;
                        ptr_q <= ptr_q + 1'b1;
                    end
                    if (scl_fall) cnt_q <= '0;
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        tx_q  <= {tx_q[BYTE_W-2:0], 1'b1};
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) mack_q <= ~sda_s;
                    if (scl_fall) begin
                        cnt_q <= '0;
                        if (mack_q) begin
                            tx_q  <= rd_data;
                            ptr_q <= ptr_q + 1'b1;
                        end
                    end
                end
                ST_WORD_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) cnt_q <= '0;
                end
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe_o = 1'b0;
        unique case (state_q)
            ST_DEV_ACK, ST_WORD_ACK, ST_WDATA_ACK: sda_oe_o = ack_q;
            ST_RDATA:                              sda_oe_o = ~tx_q[BYTE_W-1];
            default:                               sda_oe_o = 1'b0;
        endcase
    end

    // R7
    lower_half_guarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && locked) |-> ptr_q[TOP_BIT]);

    // R6
    wr_ctrl_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !wr_ctrl_i);

    // R13
    sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

    // R11
    stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !sda_oe_o);

endmodule

// File: tb/i2c_eep_slave_tb_top.sv
module i2c_eep_slave_tb_top;

    localparam int Q = 6;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wr_ctrl = 1'b0;
    logic dut_oe;
    logic sda_line;
    int   checks = 0;
    int   errors = 0;
    int   r13_viol = 0;
    logic oe_prev = 1'b0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~dut_oe;

    i2c_eep_slave dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe_o   (dut_oe),
        .chip_sel_i (STRAP),
        .wr_ctrl_i  (wr_ctrl)
    );

    // R13 monitor: drive changes seen while SCL high
    always @(negedge clk) begin
        if (rst_n && scl_m && (dut_oe !== oe_prev)) r13_viol++;
        oe_prev = dut_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sel(input logic [3:0] kind, input logic [2:0] e, input logic rd);
        return {kind, e, rd};
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        acked = (sda_line == 1'b0);
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl_m = 1'b0;
        end
        tick(Q);
        sda_m = nack; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic write_one(input logic [7:0] a, input logic [7:0] d, output logic ad, output logic dd);
        logic s;
        bus_start();
        put_byte(sel(4'b1010, STRAP, 1'b0), s);
        put_byte(a, ad);
        put_byte(d, dd);
        bus_stop();
    endtask

    task automatic read_one(input logic [7:0] a, output logic [7:0] d);
        logic s;
        bus_start();
        put_byte(sel(4'b1010, STRAP, 1'b0), s);
        put_byte(a, s);
        bus_start();
        put_byte(sel(4'b1010, STRAP, 1'b1), s);
        get_byte(1'b1, d);
        bus_stop();
    endtask

    task automatic guard_cmd(input logic [7:0] code, output logic acked);
        logic s;
        bus_start();
        put_byte(sel(4'b0110, STRAP, 1'b0), s);
        put_byte(code, acked);
        bus_stop();
    endtask

    task automatic t_reset();
        logic a;
        logic [7:0] d;
        chk("R12 oe after reset", {7'd0, dut_oe}, 8'h00);
        bus_start();
        put_byte(sel(4'b1010, STRAP, 1'b1), a);
        chk("R12 read select ack", {7'd0, a}, 8'h01);
        get_byte(1'b1, d);
        bus_stop();
        chk("R12 byte at pointer 0", d, 8'h00);
        chk("R11 oe released after stop", {7'd0, dut_oe}, 8'h00);
    endtask

    task automatic t_byte_write();
        logic a, b;
        logic [7:0] d;
        write_one(8'h10, 8'h3C, a, b);
        chk("R2 address ack", {7'd0, a}, 8'h01);
        chk("R2 data ack", {7'd0, b}, 8'h01);
        read_one(8'h10, d);
        chk("R2 random read", d, 8'h3C);
    endtask

    task automatic t_seq_write_read();
        logic s, a0, a1, a2;
        logic [7:0] d;
        bus_start();
        put_byte(sel(4'b1010, STRAP, 1'b0), s);
        put_byte(8'h20, s);
        put_byte(8'h11, a0);
        put_byte(8'h22, a1);
        put_byte(8'h33, a2);
        bus_stop();
        chk("R5 data acks", {5'd0, a0, a1, a2}, 8'h07);
        bus_start();
        put_byte(sel(4'b1010, STRAP, 1'b0), s);
        put_byte(8'h20, s);
        bus_start();
        put_byte(sel(4'b1010, STRAP, 1'b1), s);
        get_byte(1'b0, d);
        chk("R5 seq byte 20h", d, 8'h11);
        get_byte(1'b1, d);
        chk("R5 seq byte 21h", d, 8'h22);
        bus_stop();
        chk("R4 released after no-ack", {7'd0, dut_oe}, 8'h00);
    endtask

    task automatic t_current_read();
        logic s;
        logic [7:0] d;
        bus_start();
        put_byte(sel(4'b1010, STRAP, 1'b1), s);
        get_byte(1'b1, d);
        bus_stop();
        chk("R3 current address read", d, 8'h33);
    endtask

    task automatic t_wrap();
        logic s, a0, a1, a2;
        logic [7:0] d;
        bus_start();
        put_byte(sel(4'b1010, STRAP, 1'b0), s);
        put_byte(8'hFE, s);
        put_byte(8'hAA, a0);
        put_byte(8'hBB, a1);
        put_byte(8'hCC, a2);
        bus_stop();
        chk("R4 wrap write acks", {5'd0, a0, a1, a2}, 8'h07);
        bus_start();
        put_byte(sel(4'b1010, STRAP, 1'b0), s);
        put_byte(8'hFE, s);
        bus_start();
        put_byte(sel(4'b1010, STRAP, 1'b1), s);
        get_byte(1'b0, d);
        chk("R4 read FEh", d, 8'hAA);
        get_byte(1'b0, d);
        chk("R4 read FFh", d, 8'hBB);
        get_byte(1'b1, d);
        chk("R4 read wrapped 00h", d, 8'hCC);
        bus_stop();
    endtask

    task automatic t_select_mismatch();
        logic a, x;
        logic [7:0] d;
        bus_start();
        put_byte(sel(4'b1010, 3'b010, 1'b0), a);
        bus_stop();
        chk("R1 wrong strap nack", {7'd0, a}, 8'h00);
        bus_start();
        put_byte(sel(4'b1011, STRAP, 1'b0), a);
        bus_stop();
        chk("R1 wrong type nack", {7'd0, a}, 8'h00);
        bus_start();
        put_byte(sel(4'b1010, 3'b100, 1'b0), a);
        put_byte(8'h10, x);
        put_byte(8'h55, x);
        bus_stop();
        read_one(8'h10, d);
        chk("R1 ignored write left data", d, 8'h3C);
    endtask

    task automatic t_write_control();
        logic s, a, b;
        logic [7:0] d;
        wr_ctrl = 1'b1;
        bus_start();
        put_byte(sel(4'b1010, STRAP, 1'b0), s);
        put_byte(8'hA0, a);
        put_byte(8'h77, b);
        bus_stop();
        wr_ctrl = 1'b0;
        chk("R6 select ack", {7'd0, s}, 8'h01);
        chk("R6 address ack", {7'd0, a}, 8'h01);
        chk("R6 data nack", {7'd0, b}, 8'h00);
        read_one(8'hA0, d);
        chk("R6 memory unchanged", d, 8'h00);
    endtask

    task automatic t_soft_lock();
        logic a, b;
        logic [7:0] d;
        guard_cmd(8'h00, a);
        chk("R7 soft lock ack", {7'd0, a}, 8'h01);
        write_one(8'h05, 8'h99, a, b);
        chk("R7 lower data nack", {7'd0, b}, 8'h00);
        read_one(8'h05, d);
        chk("R7 lower unchanged", d, 8'h00);
        write_one(8'h85, 8'h5A, a, b);
        chk("R7 upper data ack", {7'd0, b}, 8'h01);
        read_one(8'h85, d);
        chk("R7 upper written", d, 8'h5A);
    endtask

    task automatic t_unlock();
        logic a, b;
        logic [7:0] d;
        guard_cmd(8'h02, a);
        chk("R8 unlock ack", {7'd0, a}, 8'h01);
        write_one(8'h05, 8'h99, a, b);
        chk("R8 lower data ack", {7'd0, b}, 8'h01);
        read_one(8'h05, d);
        chk("R8 lower written", d, 8'h99);
    endtask

    task automatic t_bad_cmd();
        logic a, b;
        logic [7:0] d;
        guard_cmd(8'h07, a);
        chk("R10 unknown command nack", {7'd0, a}, 8'h00);
        bus_start();
        put_byte(sel(4'b0110, STRAP, 1'b1), a);
        bus_stop();
        chk("R10 guard read nack", {7'd0, a}, 8'h00);
        write_one(8'h08, 8'h42, a, b);
        read_one(8'h08, d);
        chk("R10 no lock after refused cmds", d, 8'h42);
    endtask

    task automatic t_hard_lock();
        logic a, b;
        logic [7:0] d;
        guard_cmd(8'h01, a);
        chk("R9 hard lock ack", {7'd0, a}, 8'h01);
        guard_cmd(8'h02, a);
        chk("R9 unlock refused", {7'd0, a}, 8'h00);
        write_one(8'h06, 8'h66, a, b);
        chk("R9 lower data nack", {7'd0, b}, 8'h00);
        read_one(8'h06, d);
        chk("R9 lower unchanged", d, 8'h00);
    endtask

    task automatic t_stop_restart();
        logic a, b, s;
        logic [7:0] d;
        write_one(8'hC0, 8'hE7, a, b);
        bus_start();
        put_byte(sel(4'b1010, STRAP, 1'b0), s);
        put_byte(8'hC0, s);
        bus_stop();
        chk("R11 idle after mid stop", {7'd0, dut_oe}, 8'h00);
        bus_start();
        put_byte(sel(4'b1010, STRAP, 1'b1), s);
        chk("R11 restart select ack", {7'd0, s}, 8'h01);
        get_byte(1'b1, d);
        bus_stop();
        chk("R11 read after restart", d, 8'hE7);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_byte_write();
        t_seq_write_read();
        t_current_read();
        t_wrap();
        t_select_mismatch();
        t_write_control();
        t_soft_lock();
        t_unlock();
        t_bad_cmd();
        t_hard_lock();
        t_stop_restart();
        chk("R13 drive changed with SCL high", r13_viol[7:0], 8'h00);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule